// File: doc/BRIEF.md
# Reference-Delay Calibration Sweep

This block calibrates the delay placed on a slave converter's incoming reference clock. After a start request it issues a register-write request for every delay code, from 0 up to the code where the delay element saturates. After each write it waits a programmable settle time. It then counts rising edges of the slave's output clock over fixed measurement windows. A code is graded stable only when every one of several consecutive windows holds exactly the expected edge count.

As the sweep runs, the block follows runs of consecutive stable codes and keeps the widest one. The slave clock can be held high, it can flicker near the border of a region, and it can toggle at the wrong rate. All three make a code unstable, so a run never includes border codes that flicker. When the sweep ends, the block writes the midpoint of the widest run back to the delay register and reports both that code and the width of the run. The midpoint is the floor of the average of the two unstable codes that bound the run. A run that touches code 0 takes -1 as its lower bound, and a run that touches the last code takes one past the last code as its upper bound. If no code is stable, the block raises an error and writes code 0.

Top module: `dly_win_finder`

## Requirements
- R1: After reset, wr_valid, busy, done and err are 0, and best_code and best_width are 0.
- R2: A start pulse while idle starts a sweep. The sweep issues one write for each code, in the order 0, 1, …, MAX_CODE, and issues no sweep write above MAX_CODE. Exactly one further write follows: the result write.
- R3: A code is stable only if each of NPASS (3) consecutive windows of WIN_CYC cycles contains exactly EXP_EDGES rising edges of mon_clk, counted after settle_len settle cycles. A clock held high is unstable. A clock that toggles at the wrong rate is also unstable.
- R4: A code whose clock toggles only during part of its measurement is unstable. Such a code passes fewer than NPASS windows.
- R5: Of all runs of consecutive stable codes, the longest is chosen. When two runs have the same length, the one with the lower codes wins.
- R6: The result code is floor((lo + hi) / 2), where lo and hi are the unstable codes just outside the chosen run. A run at the edge of the range uses -1 or MAX_CODE+1 as the missing bound. The result code is the value of the final write, and it appears on best_code when done is high.
- R7: When done is high, best_width equals the number of codes in the chosen run.
- R8: If no code is stable, then err is 1 when done is high, the final write carries code 0, and best_code and best_width are both 0.
- R9: A start pulse during a sweep is ignored, and the write sequence continues unchanged.
- R10: done is high for exactly one cycle, in the cycle after the result write. busy is high from the cycle after start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sweep request pulse |
| settle_len | input | SETTLE_W | Settle cycles after each code write |
| mon_clk | input | 1 | Monitored slave output clock, asynchronous |
| wr_valid | output | 1 | Delay-register write request |
| wr_code | output | CODE_W | Delay code carried by the write |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No stable code found |
| best_code | output | CODE_W | Chosen delay code |
| best_width | output | WID_W | Length of the chosen run |

## Verification
A fault in the window grading shows up when a result is reported. Accepting a code that flickers or toggles at the wrong rate widens or moves the winning run, so best_code or best_width differs at done. A fault in the code counter or the FSM shows up within one write: the next value on wr_code is out of order, or a write is missing or extra. Faults in run tracking show up only at the end of a sweep. To expose them, each scenario places several regions, including ties and runs that touch either end of the range, so that any wrong choice changes the final write.

// File: rtl/dwf_pkg.sv
package dwf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WRITE, ST_JUDGE, ST_FINAL, ST_DONE
  } fsm_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SETTLE, PH_WIN
  } jphase_t;
endpackage

// File: rtl/dwf_judge.sv
module dwf_judge #(
  parameter int SETTLE_W  = 8,
  parameter int WIN_CYC   = 16,
  parameter int EXP_EDGES = 4,
  parameter int NPASS     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [SETTLE_W-1:0] settle,
  input  logic                mon_clk,
  output logic                valid,
  output logic                good
);
  import dwf_pkg::*;
  localparam int TW = (SETTLE_W > $clog2(WIN_CYC)) ? SETTLE_W : $clog2(WIN_CYC);
  localparam int EW = $clog2(WIN_CYC + 1);
  localparam int PW = $clog2(NPASS + 1);

  function automatic logic window_ok(input logic [EW-1:0] cnt);
    return cnt == EW'(EXP_EDGES);
  endfunction

  logic          s1, s2, s3, rise;
  jphase_t       ph;
  logic [TW-1:0] tmr;
  logic [EW-1:0] edges, edges_nx;
  logic [PW-1:0] passes;

  assign rise     = s2 & ~s3;
  assign edges_nx = edges + EW'(rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= mon_clk; s2 <= s1; s3 <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; tmr <= '0; edges <= '0; passes <= '0;
      valid <= 1'b0; good <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (go) begin
        ph <= PH_SETTLE; tmr <= TW'(settle); edges <= '0; passes <= '0;
      end else begin
        case (ph)
          PH_SETTLE: begin
            if (tmr == '0) begin
              ph <= PH_WIN; tmr <= TW'(WIN_CYC - 1); edges <= '0;
            end else tmr <= tmr - 1'b1;
          end
          PH_WIN: begin
            if (tmr == '0) begin
              if (window_ok(edges_nx)) begin
                if (passes == PW'(NPASS - 1)) begin
                  valid <= 1'b1; good <= 1'b1; ph <= PH_IDLE;
                end else begin
                  passes <= passes + 1'b1; tmr <= TW'(WIN_CYC - 1); edges <= '0;
                end
              end else begin
                valid <= 1'b1; good <= 1'b0; ph <= PH_IDLE;
              end
            end else begin
              tmr <= tmr - 1'b1; edges <= edges_nx;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dwf_runtrack.sv
module dwf_runtrack #(
  parameter int CODE_W = 9,
  parameter int WID_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              good,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] best_start,
  output logic [WID_W-1:0]  best_len
);
  logic [CODE_W-1:0] run_start, ns;
  logic [WID_W-1:0]  run_len, nl;

  assign nl = run_len + 1'b1;
  assign ns = (run_len == '0) ? code : run_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_start <= '0; run_len <= '0; best_start <= '0; best_len <= '0;
    end else if (clr) begin
      run_start <= '0; run_len <= '0; best_start <= '0; best_len <= '0;
    end else if (upd) begin
      if (good) begin
        run_len <= nl; run_start <= ns;
        if (nl > best_len) begin
          best_len <= nl; best_start <= ns;
        end
      end else begin
        run_len <= '0;
      end
    end
  end
endmodule

// File: rtl/dly_win_finder.sv
module dly_win_finder #(
  parameter int CODE_W    = 9,
  parameter int MAX_CODE  = 319,
  parameter int SETTLE_W  = 8,
  parameter int WIN_CYC   = 16,
  parameter int EXP_EDGES = 4,
  parameter int NPASS     = 3,
  parameter int WID_W     = $clog2(MAX_CODE + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_len,
  input  logic                mon_clk,
  output logic                wr_valid,
  output logic [CODE_W-1:0]   wr_code,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [CODE_W-1:0]   best_code,
  output logic [WID_W-1:0]    best_width
);
  import dwf_pkg::*;

  function automatic logic [CODE_W-1:0] mid_code(input logic [CODE_W-1:0] s,
                                                 input logic [WID_W-1:0] n);
    logic [CODE_W+1:0] t;
    t = {1'b0, s, 1'b0} + (CODE_W+2)'(n) - 1'b1;
    return CODE_W'(t >> 1);
  endfunction

  fsm_t              st;
  logic [CODE_W-1:0] code, result, run_s;
  logic [WID_W-1:0]  run_n;
  logic              sweep_wr, final_wr, judge_valid, judge_good, sweep_clr, last_code;

  assign sweep_wr  = (st == ST_WRITE);
  assign final_wr  = (st == ST_FINAL);
  assign sweep_clr = (st == ST_IDLE) && start;
  assign last_code = (code == CODE_W'(MAX_CODE));
  assign result    = (run_n == '0) ? '0 : mid_code(run_s, run_n);
  assign wr_valid  = sweep_wr | final_wr;
  assign wr_code   = final_wr ? result : code;
  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);

  dwf_judge #(.SETTLE_W(SETTLE_W), .WIN_CYC(WIN_CYC), .EXP_EDGES(EXP_EDGES), .NPASS(NPASS)) judge_i (
    .clk(clk), .rst_n(rst_n), .go(sweep_wr), .settle(settle_len), .mon_clk(mon_clk),
    .valid(judge_valid), .good(judge_good));

  dwf_runtrack #(.CODE_W(CODE_W), .WID_W(WID_W)) track_i (
    .clk(clk), .rst_n(rst_n), .clr(sweep_clr), .upd(judge_valid && st == ST_JUDGE),
    .good(judge_good), .code(code), .best_start(run_s), .best_len(run_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; code <= '0; err <= 1'b0; best_code <= '0; best_width <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_WRITE; code <= '0; err <= 1'b0; best_code <= '0; best_width <= '0;
        end
        ST_WRITE: st <= ST_JUDGE;
        ST_JUDGE: if (judge_valid) begin
          if (last_code) st <= ST_FINAL;
          else begin
            code <= code + 1'b1; st <= ST_WRITE;
          end
        end
        ST_FINAL: begin
          best_code <= result; best_width <= run_n; err <= (run_n == '0);
          st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dwf_chk.sv
module dwf_chk #(
  parameter int CODE_W   = 9,
  parameter int MAX_CODE = 319,
  parameter int WID_W    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              sweep_wr,
  input logic              final_wr,
  input logic              judge_valid,
  input logic [CODE_W-1:0] wr_code,
  input logic [CODE_W-1:0] best_code,
  input logic [WID_W-1:0]  best_width
);
  logic [CODE_W:0] exp_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exp_next <= '0;
    else if (start && !busy) exp_next <= '0;
    else if (sweep_wr) exp_next <= {1'b0, wr_code} + 1'b1;
  end

  a_r2_code_order: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_wr |-> {1'b0, wr_code} == exp_next);
  a_r2_stop_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    final_wr |-> exp_next == (CODE_W+1)'(MAX_CODE + 1));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(final_wr));
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (best_code == '0 && best_width == '0));
  a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ({1'b0, best_code} <= (CODE_W+1)'(MAX_CODE) && best_width != '0));
  a_r3_judge_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    judge_valid |-> busy);
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind dly_win_finder dwf_chk #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE), .WID_W(WID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
  .sweep_wr(sweep_wr), .final_wr(final_wr), .judge_valid(judge_valid),
  .wr_code(wr_code), .best_code(best_code), .best_width(best_width));

// File: tb/dly_win_finder_tb_top.sv
module dly_win_finder_tb_top;
  localparam int CW = 9, MAXC = 319, WW = $clog2(MAXC + 2);

  logic clk = 0, rst_n = 0, start = 0, mon_clk;
  logic [7:0] settle_len = 8'd3;
  logic wr_valid, busy, done, err;
  logic [CW-1:0] wr_code, best_code;
  logic [WW-1:0] best_width;

  int checks = 0, errors = 0, scen = 0, cur = 0, age = 0, cyc = 0;
  logic [1:0] div = '0;
  int wq[$];

  always #2 clk = ~clk;

  dly_win_finder dut_i (.clk(clk), .rst_n(rst_n), .start(start), .settle_len(settle_len),
    .mon_clk(mon_clk), .wr_valid(wr_valid), .wr_code(wr_code), .busy(busy), .done(done),
    .err(err), .best_code(best_code), .best_width(best_width));

  // slave model: 0 held high, 1 correct rate, 2 flicker, 3 double rate
  function automatic int kind_of(input int s, input int c);
    case (s)
      1: begin
        if ((c >= 10 && c <= 40) || (c >= 100 && c <= 180)) return 1;
        if (c == 9 || c == 98 || c == 99 || c == 181) return 2;
      end
      2: if (c == 5 || c == 200) return 2;
      3: if (c <= 50 || c >= 270) return 1;
      4: begin
        if ((c >= 20 && c <= 29) || (c >= 60 && c <= 69) || (c >= 100 && c <= 105)) return 1;
        if (c >= 150 && c <= 200) return 3;
      end
      5: if (c <= 9 || c >= 250) return 1;
      default: ;
    endcase
    return 0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    div <= div + 1'b1;
    if (wr_valid) begin cur <= int'(wr_code); age <= 0; end
    else if (age < 1000) age <= age + 1;
  end

  always_comb begin
    case (kind_of(scen, cur))
      1: mon_clk = div[1];
      2: mon_clk = (age < 20) ? div[1] : 1'b1;
      3: mon_clk = div[0];
      default: mon_clk = 1'b1;
    endcase
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: every write is compared to the scoreboard queue (R2, R6, R8, R9)
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (wq.size() == 0) check(0, "R2 unexpected write", int'(wr_code), -1);
      else begin
        int e;
        e = wq.pop_front();
        check(int'(wr_code) == e, "R2/R6 write code", int'(wr_code), e);
      end
    end
  end

  task automatic run_sweep(input int s, input int st, input bit e_err, input int e_code,
                           input int e_wid, input bit poke);
    scen = s;
    settle_len = 8'(st);
    for (int c = 0; c <= MAXC; c++) wq.push_back(c);
    wq.push_back(e_code);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (500) @(negedge clk);
      start = 1;  // R9: must be ignored
      @(negedge clk) start = 0;
    end
    while (!done) @(negedge clk);
    check(err == e_err, "R8 err flag", int'(err), int'(e_err));
    check(int'(best_code) == e_code, "R6 best_code", int'(best_code), e_code);
    check(int'(best_width) == e_wid, "R7 best_width", int'(best_width), e_wid);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R10 single done pulse", int'(done), 0);
    check(wq.size() == 0, "R2 all codes written", wq.size(), 0);
    wq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(wr_valid == 0 && busy == 0 && done == 0 && err == 0, "R1 idle outputs", int'(busy), 0);
    check(best_code == 0 && best_width == 0, "R1 result regs", int'(best_code), 0);
    rst_n = 1;
    @(negedge clk);
    // R3 R4 R5 R9: two regions, flickering borders, start poked mid-sweep; lo 99 hi 181
    run_sweep(1, 3, 0, (99 + 181) / 2, 81, 1);
    // R8: nothing stable, only flicker codes
    run_sweep(2, 3, 1, 0, 0, 0);
    // R6: runs touching both ends, longer settle; lo -1 hi 51
    run_sweep(3, 12, 0, (-1 + 51) / 2, 51, 0);
    // R5 tie goes to lower run, R3 double-rate region rejected; lo 19 hi 30
    run_sweep(4, 3, 0, (19 + 30) / 2, 10, 0);
    // R6 run ending at the last code; lo 249 hi 320
    run_sweep(5, 3, 0, (249 + MAXC + 1) / 2, 70, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule